// File: doc/BRIEF.md
# Two-wire pointer-addressed register slave

This block is a slave on a two-wire serial bus (I2C and SMBus compatible). A master reaches a small file of 16-bit registers through it. SCL and SDA come in as ordinary inputs and are oversampled in the system clock domain. The block pulls SDA low through an open-drain style enable, `sda_oe_o`, and it never drives SCL. The bus address of the slave is set partly in hardware and partly by a two-bit strap.

A write transaction always starts with a pointer byte. Any bytes that follow the pointer are data, and the block takes them in pairs: the first byte of a pair is the high byte and the second is the low byte. The pointer keeps its value after the transaction ends. A later read returns the selected register over the bus with the high byte first. Register 0 is read-only from the bus. Its value comes from a simple update port that the surrounding logic drives, and that port can also load any of the other registers.

Top module: `twi_ptr_slave`

## Requirements
- R1: The 7-bit device address is binary 10010 followed by the two strap bits `addr_sel_i` (bit 1 first). The slave acknowledges an address byte only when these match. For any other address it leaves SDA released and ignores the bus until the next START.
- R2: After a matching address with R/W = 0 (R/W is the last bit of the address byte), the next byte is the pointer. Its low two bits are stored, its upper six bits are ignored, and the byte is acknowledged.
- R3: Bytes that follow the pointer in the same write are acknowledged and taken in pairs, high byte then low byte. A register is updated only when the low byte of a pair arrives. A high byte with no low byte after it is discarded.
- R4: A read (R/W = 1) returns the register selected by the pointer. The high byte goes out first, then the low byte. Bits go MSB first. If the master acknowledges further bytes, the slave keeps alternating between the high and low bytes.
- R5: The pointer keeps its value across transactions until a later write changes it. A write that carries only the address and the pointer changes no register.
- R6: Bus writes to register 0 are acknowledged but leave its value unchanged.
- R7: During a read, a NACK from the master, a START, or a STOP ends the transfer, and SDA is released from then on.
- R8: A repeated START ends a write, and the address byte that follows it may start a read in the same bus session.
- R9: When `upd_en_i` is high at a clock edge, the register `upd_idx_i` is loaded from `upd_data_i`.
- R10: The slave begins pulling SDA low only while SCL is low.
- R11: After reset, SDA is released, the pointer is 0, and every register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; must run many times faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| addr_sel_i | input | 2 | Strap for the two low address bits |
| upd_en_i | input | 1 | Update-port write strobe |
| upd_idx_i | input | 2 | Update-port register index |
| upd_data_i | input | 16 | Update-port write data |

## Verification
A wrong pointer or a wrong pairing state appears at the ports on the next read. That read returns the wrong register, or a stale or half-written value, in the first byte after the address acknowledge. A wrong bit counter or a wrong phase in the ACK handling shows up at once, within one SCL period. The slave either acknowledges on the wrong clock or fails to release SDA, and a later byte or a following START is then corrupted. A broken address compare or a broken read-only mask shows up in a single transaction, as a wrong ACK level or as a changed register 0.

// File: rtl/twi_ptr_pkg.sv
package twi_ptr_pkg;
  localparam int DW = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } twi_st_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } rx_kind_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  // idle bus level is high, so reset to 1 to avoid a false edge
  for (genvar l = 0; l < N; l++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-1:0], line_i[l]};
    end
    assign cur_o[l]  = pipe_q[STAGES-1];
    assign prev_o[l] = pipe_q[STAGES];
  end
endmodule

// File: rtl/twi_reg_file.sv
module twi_reg_file #(
  parameter int              NREG    = 4,
  parameter int              DW      = 16,
  parameter logic [NREG-1:0] RO_MASK = NREG'(1),
  localparam int             IW      = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_we_i,
  input  logic [IW-1:0]            bus_idx_i,
  input  logic [DW-1:0]            bus_data_i,
  input  logic                     upd_en_i,
  input  logic [IW-1:0]            upd_idx_i,
  input  logic [DW-1:0]            upd_data_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic BUS_RO = RO_MASK[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[g] <= '0;
      end else if (upd_en_i && upd_idx_i == IW'(g)) begin
        regs_o[g] <= upd_data_i;
      end else if (!BUS_RO && bus_we_i && bus_idx_i == IW'(g)) begin
        regs_o[g] <= bus_data_i;
      end
    end
  end
endmodule

// File: rtl/twi_ptr_slave.sv
module twi_ptr_slave
  import twi_ptr_pkg::*;
#(
  parameter int              NREG    = 4,
  parameter logic [4:0]      ADDR_HI = 5'b10010,
  parameter logic [NREG-1:0] RO_MASK = NREG'(1),
  localparam int             IW      = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [1:0]    addr_sel_i,
  input  logic          upd_en_i,
  input  logic [IW-1:0] upd_idx_i,
  input  logic [DW-1:0] upd_data_i
);
  logic [1:0] line_cur, line_prev;
  logic       scl_s, sda_s, scl_p, sda_p;
  logic       scl_rise, scl_fall, start_det, stop_det;

  twi_line_sync #(.N(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({scl_i, sda_i}),
    .cur_o  (line_cur),
    .prev_o (line_prev)
  );

  assign {scl_s, sda_s} = line_cur;
  assign {scl_p, sda_p} = line_prev;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  twi_st_e   st_q;
  rx_kind_e  kind_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] sh_q, tx_sh_q, hi_q;
  logic       ack_ph_q, rw_q, hi_done_q, byte_sel_q;
  logic [IW-1:0] ptr_q;

  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0] tx_word;
  logic [7:0]    rx_byte, next_tx;
  logic [6:0]    dev_addr;
  logic          bus_we;

  assign rx_byte  = {sh_q[6:0], sda_s};
  assign dev_addr = {ADDR_HI, addr_sel_i};
  assign tx_word  = regs[ptr_q];
  assign next_tx  = byte_sel_q ? tx_word[7:0] : tx_word[15:8];
  // commit on the low byte of a pair
  assign bus_we   = (st_q == ST_RX) && (kind_q == K_DATA) && scl_rise &&
                    (bit_cnt_q == 3'd7) && hi_done_q;

  twi_reg_file #(.NREG(NREG), .DW(DW), .RO_MASK(RO_MASK)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we),
    .bus_idx_i  (ptr_q),
    .bus_data_i ({hi_q, rx_byte}),
    .upd_en_i   (upd_en_i),
    .upd_idx_i  (upd_idx_i),
    .upd_data_i (upd_data_i),
    .regs_o     (regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      kind_q     <= K_ADDR;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      tx_sh_q    <= '0;
      hi_q       <= '0;
      ack_ph_q   <= 1'b0;
      rw_q       <= 1'b0;
      hi_done_q  <= 1'b0;
      byte_sel_q <= 1'b0;
      ptr_q      <= '0;
      sda_oe_o   <= 1'b0;
    end else if (start_det) begin
      st_q      <= ST_RX;
      kind_q    <= K_ADDR;
      bit_cnt_q <= '0;
      hi_done_q <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else if (stop_det) begin
      st_q     <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (st_q)
        ST_RX: if (scl_rise) begin
          sh_q      <= rx_byte;
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            ack_ph_q <= 1'b0;
            case (kind_q)
              K_ADDR: begin
                if (rx_byte[7:1] == dev_addr) begin
                  rw_q <= rx_byte[0];
                  st_q <= ST_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              K_PTR: begin
                ptr_q <= rx_byte[IW-1:0];
                st_q  <= ST_ACK;
              end
              default: begin
                if (!hi_done_q) hi_q <= rx_byte;
                hi_done_q <= ~hi_done_q;
                st_q      <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          if (!ack_ph_q) begin
            sda_oe_o <= 1'b1;
            ack_ph_q <= 1'b1;
          end else begin
            ack_ph_q  <= 1'b0;
            bit_cnt_q <= '0;
            if (kind_q == K_ADDR && rw_q) begin
              st_q       <= ST_TX;
              tx_sh_q    <= tx_word[15:8];
              sda_oe_o   <= ~tx_word[15];
              byte_sel_q <= 1'b1;
            end else begin
              st_q     <= ST_RX;
              sda_oe_o <= 1'b0;
              kind_q   <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt_q == 3'd7) begin
            sda_oe_o  <= 1'b0;
            st_q      <= ST_MACK;
            ack_ph_q  <= 1'b0;
            bit_cnt_q <= '0;
          end else begin
            tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
            sda_oe_o  <= ~tx_sh_q[6];
            bit_cnt_q <= bit_cnt_q + 3'd1;
          end
        end
        ST_MACK: begin
          if (!ack_ph_q) begin
            if (scl_rise) begin
              if (sda_s) st_q <= ST_IDLE;
              else       ack_ph_q <= 1'b1;
            end
          end else if (scl_fall) begin
            ack_ph_q   <= 1'b0;
            st_q       <= ST_TX;
            bit_cnt_q  <= '0;
            tx_sh_q    <= next_tx;
            sda_oe_o   <= ~next_tx[7];
            byte_sel_q <= ~byte_sel_q;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_ptr_slave_chk.sv
module twi_ptr_slave_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          sda_oe_i,
  input logic          upd_en_i,
  input logic [DW-1:0] reg0_i,
  input logic          idle_i
);
  assert_drive_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);

  assert_stop_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  assert_start_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  assert_reg0_bus_proof_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(reg0_i));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_oe_i);
endmodule

bind twi_ptr_slave twi_ptr_slave_chk #(.DW(twi_ptr_pkg::DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s_i  (scl_s),
  .start_i  (start_det),
  .stop_i   (stop_det),
  .sda_oe_i (sda_oe_o),
  .upd_en_i (upd_en_i),
  .reg0_i   (regs[0]),
  .idle_i   (st_q == twi_ptr_pkg::ST_IDLE)
);

// File: tb/twi_ptr_slave_tb.sv
`timescale 1ns/1ps
module twi_ptr_slave_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [1:0] strap = 2'b10;
  logic upd_en = 1'b0;
  logic [1:0] upd_idx = '0;
  logic [15:0] upd_data = '0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_ptr_slave u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .addr_sel_i (strap),
    .upd_en_i   (upd_en),
    .upd_idx_i  (upd_idx),
    .upd_data_i (upd_data)
  );

  typedef struct {
    string      req;
    logic [7:0] val;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] act_q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(string req, logic [7:0] v);
    exp_t e;
    e.req = req;
    e.val = v;
    exp_q.push_back(e);
  endtask

  // monitor: pairs observed bus bytes/ack levels with expectations
  always @(negedge clk) begin
    if (act_q.size() > 0) begin
      logic [7:0] a;
      a = act_q.pop_front();
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected", a, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(a === e.val, e.req, a, e.val);
      end
    end
  end

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
  endtask

  // ack_exp: 1 when the slave should acknowledge (line low)
  task automatic send_byte(logic [7:0] b, string req, bit ack_exp);
    push_exp(req, ack_exp ? 8'h00 : 8'h01);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half();
      scl_m = 1'b1; half(); half();
      scl_m = 1'b0; half();
    end
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    act_q.push_back({7'b0, sda_line});
    half();
    scl_m = 1'b0; half();
  endtask

  task automatic recv_byte(logic [7:0] exp, string req, bit mack);
    logic [7:0] v;
    push_exp(req, exp);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; half();
      scl_m = 1'b1; half();
      v[i] = sda_line;
      half();
      scl_m = 1'b0; half();
    end
    sda_m = mack ? 1'b0 : 1'b1; half();
    scl_m = 1'b1; half(); half();
    scl_m = 1'b0; half();
    sda_m = 1'b1;
    act_q.push_back(v);
  endtask

  function automatic logic [7:0] dev(logic [1:0] s, bit rd);
    return {5'b10010, s, rd};
  endfunction

  task automatic upd(logic [1:0] idx, logic [15:0] d);
    @(negedge clk);
    upd_en = 1'b1; upd_idx = idx; upd_data = d;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic read_word(logic [1:0] s, logic [15:0] exp, string req);
    bus_start();
    send_byte(dev(s, 1'b1), req, 1'b1);
    recv_byte(exp[15:8], req, 1'b1);
    recv_byte(exp[7:0], req, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(sda_oe === 1'b0, "R11 reset release", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe === 1'b0, "R11 idle release", sda_oe, 0);

    // R11: pointer 0, registers zero
    read_word(2'b10, 16'h0000, "R11 reset regs");

    // R1: wrong address is not acknowledged
    bus_start();
    send_byte(dev(2'b00, 1'b0), "R1 mismatch nack", 1'b0);
    bus_stop();

    // R9 + R4: update port loads reg0, read back MSB byte first
    upd(2'd0, 16'hBEEF);
    bus_start();
    send_byte(dev(2'b10, 1'b0), "R2 addr ack", 1'b1);
    send_byte(8'h00, "R2 ptr ack", 1'b1);
    bus_stop();
    read_word(2'b10, 16'hBEEF, "R4 reg0 read");

    // R3: write reg1, then R5 read without new pointer
    bus_start();
    send_byte(dev(2'b10, 1'b0), "R3 addr", 1'b1);
    send_byte(8'h01, "R3 ptr", 1'b1);
    send_byte(8'h12, "R3 hi ack", 1'b1);
    send_byte(8'h34, "R3 lo ack", 1'b1);
    bus_stop();
    read_word(2'b10, 16'h1234, "R5 ptr kept");

    // R6: bus write to reg0 acked but ignored
    bus_start();
    send_byte(dev(2'b10, 1'b0), "R6 addr", 1'b1);
    send_byte(8'h00, "R6 ptr", 1'b1);
    send_byte(8'hAA, "R6 hi ack", 1'b1);
    send_byte(8'h55, "R6 lo ack", 1'b1);
    bus_stop();
    read_word(2'b10, 16'hBEEF, "R6 reg0 unchanged");

    // R3: four data bytes, last pair wins
    bus_start();
    send_byte(dev(2'b10, 1'b0), "R3 addr", 1'b1);
    send_byte(8'h02, "R3 ptr", 1'b1);
    send_byte(8'h11, "R3 b0", 1'b1);
    send_byte(8'h22, "R3 b1", 1'b1);
    send_byte(8'h33, "R3 b2", 1'b1);
    send_byte(8'h44, "R3 b3", 1'b1);
    bus_stop();
    read_word(2'b10, 16'h3344, "R3 pair commit");

    // R3: lone high byte is discarded
    bus_start();
    send_byte(dev(2'b10, 1'b0), "R3 addr", 1'b1);
    send_byte(8'h03, "R3 ptr", 1'b1);
    send_byte(8'h77, "R3 lone ack", 1'b1);
    bus_stop();
    read_word(2'b10, 16'h0000, "R3 lone discarded");

    // R8: pointer write, repeated start, read of reg1
    bus_start();
    send_byte(dev(2'b10, 1'b0), "R8 addr", 1'b1);
    send_byte(8'h01, "R8 ptr", 1'b1);
    bus_start();
    send_byte(dev(2'b10, 1'b1), "R8 rd addr", 1'b1);
    recv_byte(8'h12, "R8 rd hi", 1'b1);
    recv_byte(8'h34, "R8 rd lo", 1'b0);
    bus_stop();

    // R2: upper pointer bits ignored (0xFE -> reg2); R4 alternation
    bus_start();
    send_byte(dev(2'b10, 1'b0), "R2 addr", 1'b1);
    send_byte(8'hFE, "R2 ptr masked", 1'b1);
    bus_start();
    send_byte(dev(2'b10, 1'b1), "R4 rd addr", 1'b1);
    recv_byte(8'h33, "R4 b0", 1'b1);
    recv_byte(8'h44, "R4 b1", 1'b1);
    recv_byte(8'h33, "R4 b2 wrap", 1'b0);
    // R7: released after master NACK
    check(sda_oe === 1'b0, "R7 nack release", sda_oe, 0);
    check(sda_line === 1'b1, "R7 line high", sda_line, 1);
    bus_stop();

    // R5: address+pointer only changes no register
    bus_start();
    send_byte(dev(2'b10, 1'b0), "R5 addr", 1'b1);
    send_byte(8'h02, "R5 ptr", 1'b1);
    bus_stop();
    read_word(2'b10, 16'h3344, "R5 no data");

    // R1: strap change moves the address
    strap = 2'b11;
    repeat (4) @(negedge clk);
    bus_start();
    send_byte(dev(2'b10, 1'b1), "R1 old addr nack", 1'b0);
    bus_stop();
    read_word(2'b11, 16'h3344, "R1 new addr");

    // R9: update port on reg1
    upd(2'd1, 16'hC0DE);
    bus_start();
    send_byte(dev(2'b11, 1'b0), "R9 addr", 1'b1);
    send_byte(8'h01, "R9 ptr", 1'b1);
    bus_stop();
    read_word(2'b11, 16'hC0DE, "R9 upd reg1");

    // R7: STOP after one acked read byte releases SDA
    bus_start();
    send_byte(dev(2'b11, 1'b1), "R7 addr", 1'b1);
    recv_byte(8'hC0, "R7 hi", 1'b1);
    // slave now drives bit 7 of low byte (0xDE -> 1, released); abort by STOP
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
    scl_m = 1'b0; half();
    bus_stop();
    repeat (6) @(negedge clk);
    check(sda_oe === 1'b0, "R7 stop release", sda_oe, 0);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drain", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule